// File: doc/BRIEF.md
# Indirect-Access Configuration Register Bank

This block holds a small set of 16-bit configuration registers that software reaches through two locations on one access port. Writing the pointer location (`acc_sel` = 0) stores an index; the data location (`acc_sel` = 1) then reads or writes the register that index selects. Reads are combinational from the register the held pointer selects. The data port is 32 bits wide. Only the low 16 bits carry register content, in both the word and the dword access mode. The mode bit itself lives in the bank and is brought out for the bus logic.

The registers belong to different reset classes. A hard reset (`rst_n` low) loads every defined register with its default. A soft reset pulse clears only the dword-mode bit and the two locked feature bits. A feature register can be written by software only while an enable bit in a separate lock register is set. A nonvolatile loader may write any defined register through a strobe, index and data interface. It bypasses the lock and wins over a software write to the same register in the same cycle. One scratch register starts with no defined value and carries a valid flag. A decoded output reports when the raw serial port is chosen as the active network port.

Index map: 2 bus configuration (bit 7 = dword mode), 3 lock (bit 15 = feature write enable), 4 feature (bit 4 = serial enable, bit 3 = short-frame accept, other bits absent), 5 port (bits 8:7 = port select), 6 scratch. Every other index is reserved.

Top module: `cfg_bank`

## Requirements
- R1: A write with `acc_sel` = 0 stores `acc_wdata[6:0]` as the pointer. A read with `acc_sel` = 0 returns the pointer zero-extended. Hard reset sets the pointer to 0; soft reset leaves it unchanged.
- R2: A write with `acc_sel` = 1 updates the register at the pointer from `acc_wdata[15:0]` at the next clock edge. A read with `acc_sel` = 1 returns that register in the same cycle.
- R3: `acc_rdata[31:16]` is always zero and `acc_wdata[31:16]` never reaches a register, whether `dword_mode` is 0 or 1. `dword_mode` equals bit 7 of index 2.
- R4: After hard reset, index 2 reads 0x0A40, index 3 reads 0x0000, index 4 reads 0x0000, index 5 reads 0x0001, and `cfg_valid` is 0.
- R5: A soft reset clears bit 7 of index 2 and bits 4 and 3 of index 4. It leaves every other register bit, the pointer and `cfg_valid` as they were.
- R6: Software writes change bits 4 and 3 of index 4 only while bit 15 of index 3 is 1. Otherwise they are dropped. The other bits of index 4 always read 0.
- R7: Indices 0, 1 and 7 to 127 are reserved. Writes to them by software or by the loader are discarded, and reads from them return zero.
- R8: Index 6 reads zero and `cfg_valid` is 0 until the first software or loader write to it. From then on it returns the written value and `cfg_valid` stays 1 until hard reset.
- R9: A pulse on `ld_stb` writes `ld_data` to index `ld_idx` at the next edge and ignores the lock. When software writes the same index in that cycle, the loaded value wins. When software writes a different index, both writes take effect.
- R10: `raw_port_active` is 1 exactly when bit 4 of index 4 is 1 and bits 8:7 of index 5 equal binary 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| soft_rst | input | 1 | Synchronous soft reset pulse |
| acc_we | input | 1 | Write strobe for the access port |
| acc_sel | input | 1 | 0 selects the pointer location, 1 selects the data location |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Combinational read data |
| ld_stb | input | 1 | Loader write strobe |
| ld_idx | input | 7 | Loader target index |
| ld_data | input | 16 | Loader data |
| dword_mode | output | 1 | Current access width mode |
| raw_port_active | output | 1 | Raw serial port selected as the active network port |
| cfg_valid | output | 1 | Scratch register holds a written value |

## Verification
The assertions assume that every input is a known value at each clock edge once reset is released. They also assume that the loader strobe is a single-cycle pulse with a stable index and stable data during that cycle. The lock-stability property further assumes that no loader write happens while it checks, so it is conditioned on `ld_stb` being low. The stimulus drives every input on the falling edge and returns the strobes to zero one cycle later. Random loader writes target both defined and reserved indices, so the property is exercised with the lock both open and closed.

// File: rtl/cfgbank_pkg.sv
// Shared constants for the configuration bank: index map, bit positions
// and per-index masks. Assumes 16-bit registers and 7-bit indices.
package cfgbank_pkg;
    localparam int REG_W      = 16;
    localparam int IDX_BUS    = 2;
    localparam int IDX_LOCK   = 3;
    localparam int IDX_FEAT   = 4;
    localparam int IDX_PORT   = 5;
    localparam int IDX_SCR    = 6;
    localparam int FIRST_CTL  = IDX_BUS;
    localparam int N_CTL      = IDX_PORT - IDX_BUS + 1;
    localparam int BUS_DWORD  = 7;
    localparam int LOCK_EN    = 15;
    localparam int FEAT_SER   = 4;
    localparam int PSEL_LO    = 7;

    // Bits that exist in a register
    function automatic logic [REG_W-1:0] f_impl(int idx);
        case (idx)
            IDX_FEAT: return 16'h0018;
            IDX_BUS, IDX_LOCK, IDX_PORT, IDX_SCR: return 16'hFFFF;
            default: return 16'h0000;
        endcase
    endfunction

    // Bits cleared by the soft reset
    function automatic logic [REG_W-1:0] f_soft(int idx);
        case (idx)
            IDX_BUS:  return 16'h0080;
            IDX_FEAT: return 16'h0018;
            default:  return 16'h0000;
        endcase
    endfunction

    // Bits whose software write needs the lock enable
    function automatic logic [REG_W-1:0] f_gate(int idx);
        return (idx == IDX_FEAT) ? 16'h0018 : 16'h0000;
    endfunction

    // Hard reset value
    function automatic logic [REG_W-1:0] f_def(int idx);
        case (idx)
            IDX_BUS:  return 16'h0A40;
            IDX_PORT: return 16'h0001;
            default:  return 16'h0000;
        endcase
    endfunction
endpackage

// File: rtl/cfgbank_ptr.sv
// Index pointer register. Loads on a pointer-location write; only the hard
// reset clears it. Assumes the write strobe is qualified by the caller.
module cfgbank_ptr #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] d,
    output logic [PTR_W-1:0] q
);
    // Hold or load the pointer
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/cfgbank_reg.sv
// One defined control register with its reset class and write gating.
// Loader writes win over software writes and skip the lock; soft reset is
// applied after both, so it wins over a same-cycle write of its bits.
module cfgbank_reg
    import cfgbank_pkg::*;
#(
    parameter logic [REG_W-1:0] IMPL = '1,
    parameter logic [REG_W-1:0] SOFT = '0,
    parameter logic [REG_W-1:0] GATE = '0,
    parameter logic [REG_W-1:0] DEF  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_data,
    input  logic             ld_we,
    input  logic [REG_W-1:0] ld_data,
    input  logic             gate_open,
    output logic [REG_W-1:0] q
);
    logic [REG_W-1:0] nxt;
    logic [REG_W-1:0] keep;

    // Next value: loader, then gated software write, then soft clear
    always_comb begin
        keep = gate_open ? '0 : GATE;
        nxt  = q;
        if (ld_we)      nxt = ld_data & IMPL;
        else if (sw_we) nxt = ((sw_data & ~keep) | (q & keep)) & IMPL;
        if (soft_rst)   nxt = nxt & ~SOFT;
    end

    // State update with hard reset default
    always_ff @(posedge clk) begin
        if (!rst_n) q <= DEF;
        else        q <= nxt;
    end
endmodule

// File: rtl/cfgbank_hold.sv
// Register with no defined reset value plus a flag that marks it written.
// Data has no reset; the flag is cleared only by the hard reset.
module cfgbank_hold
    import cfgbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [REG_W-1:0] sw_data,
    input  logic             ld_we,
    input  logic [REG_W-1:0] ld_data,
    output logic [REG_W-1:0] q,
    output logic             valid
);
    // Capture data, loader first
    always_ff @(posedge clk) begin
        if (ld_we)      q <= ld_data;
        else if (sw_we) q <= sw_data;
    end

    // Track that a defined value is held
    always_ff @(posedge clk) begin
        if (!rst_n)              valid <= 1'b0;
        else if (ld_we || sw_we) valid <= 1'b1;
    end
endmodule

// File: rtl/cfg_bank.sv
// Indirect-access configuration bank top. Pointer location plus data
// location on one port; defined indices come from cfgbank_pkg and all
// others are reserved. Assumes PORT_W >= REG_W and PTR_W <= PORT_W.
module cfg_bank
    import cfgbank_pkg::*;
#(
    parameter int PTR_W  = 7,
    parameter int PORT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              acc_we,
    input  logic              acc_sel,
    input  logic [PORT_W-1:0] acc_wdata,
    output logic [PORT_W-1:0] acc_rdata,
    input  logic              ld_stb,
    input  logic [PTR_W-1:0]  ld_idx,
    input  logic [REG_W-1:0]  ld_data,
    output logic              dword_mode,
    output logic              raw_port_active,
    output logic              cfg_valid
);
    localparam int LOCK_SLOT = IDX_LOCK - FIRST_CTL;
    localparam int FEAT_SLOT = IDX_FEAT - FIRST_CTL;
    localparam int PORT_SLOT = IDX_PORT - FIRST_CTL;
    localparam int BUS_SLOT  = IDX_BUS - FIRST_CTL;

    logic [PTR_W-1:0]            ptr;
    logic [N_CTL-1:0][REG_W-1:0] ctl_q;
    logic [REG_W-1:0]            scr_q;
    logic [REG_W-1:0]            rd_word;
    logic                        sw_hit;
    logic                        lock_open;
    logic                        unused_hi;

    assign sw_hit    = acc_we && acc_sel;
    assign lock_open = ctl_q[LOCK_SLOT][LOCK_EN];
    assign unused_hi = ^acc_wdata[PORT_W-1:REG_W];

    cfgbank_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk (clk),
        .rst_n (rst_n),
        .we  (acc_we && !acc_sel),
        .d   (acc_wdata[PTR_W-1:0]),
        .q   (ptr)
    );

    for (genvar i = 0; i < N_CTL; i++) begin : g_ctl
        localparam int IDX = FIRST_CTL + i;
        cfgbank_reg #(
            .IMPL (f_impl(IDX)),
            .SOFT (f_soft(IDX)),
            .GATE (f_gate(IDX)),
            .DEF  (f_def(IDX))
        ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (soft_rst),
            .sw_we     (sw_hit && (ptr == PTR_W'(IDX))),
            .sw_data   (acc_wdata[REG_W-1:0]),
            .ld_we     (ld_stb && (ld_idx == PTR_W'(IDX))),
            .ld_data   (ld_data),
            .gate_open (lock_open),
            .q         (ctl_q[i])
        );
    end

    cfgbank_hold u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sw_we   (sw_hit && (ptr == PTR_W'(IDX_SCR))),
        .sw_data (acc_wdata[REG_W-1:0]),
        .ld_we   (ld_stb && (ld_idx == PTR_W'(IDX_SCR))),
        .ld_data (ld_data),
        .q       (scr_q),
        .valid   (cfg_valid)
    );

    // Select the register named by the pointer; reserved reads give zero
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_CTL; i++) begin
            if (ptr == PTR_W'(FIRST_CTL + i)) rd_word = ctl_q[i];
        end
        if (ptr == PTR_W'(IDX_SCR) && cfg_valid) rd_word = scr_q;
    end

    // Port read: pointer or register, upper half always zero
    always_comb begin
        acc_rdata = '0;
        if (acc_sel) acc_rdata[REG_W-1:0] = rd_word;
        else         acc_rdata[PTR_W-1:0] = ptr;
    end

    assign dword_mode      = ctl_q[BUS_SLOT][BUS_DWORD];
    assign raw_port_active = ctl_q[FEAT_SLOT][FEAT_SER] &&
                             (ctl_q[PORT_SLOT][PSEL_LO+1 -: 2] == 2'b10);
endmodule

// File: rtl/cfg_bank_chk.sv
// Checker for cfg_bank, attached by bind. Observes ports and the pointer,
// lock and register state. Assumes inputs are known at every clock edge.
module cfg_bank_chk
    import cfgbank_pkg::*;
#(
    parameter int PTR_W  = 7,
    parameter int PORT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              acc_we,
    input logic              acc_sel,
    input logic [PORT_W-1:0] acc_rdata,
    input logic              ld_stb,
    input logic [PTR_W-1:0]  ld_idx,
    input logic [REG_W-1:0]  ld_data,
    input logic              dword_mode,
    input logic              cfg_valid,
    input logic [PTR_W-1:0]  ptr,
    input logic              lock_open,
    input logic [REG_W-1:0]  feat_q,
    input logic [REG_W-1:0]  port_q
);
    // R1
    ptr_reset_chk: assert property (@(posedge clk) !rst_n |=> (ptr == '0));

    // R1
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_we && !acc_sel) |=> $stable(ptr));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdata[PORT_W-1:REG_W] == '0);

    // R5
    soft_dword_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !dword_mode);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_open && !soft_rst && !ld_stb) |=> $stable(feat_q));

    // R8
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> cfg_valid);

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_stb && acc_we && acc_sel && ld_idx == ptr && ld_idx == PTR_W'(IDX_PORT))
        |=> (port_q == $past(ld_data)));
endmodule

bind cfg_bank cfg_bank_chk #(.PTR_W(PTR_W), .PORT_W(PORT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .acc_we     (acc_we),
    .acc_sel    (acc_sel),
    .acc_rdata  (acc_rdata),
    .ld_stb     (ld_stb),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .dword_mode (dword_mode),
    .cfg_valid  (cfg_valid),
    .ptr        (ptr),
    .lock_open  (lock_open),
    .feat_q     (ctl_q[IDX_FEAT-FIRST_CTL]),
    .port_q     (ctl_q[IDX_PORT-FIRST_CTL])
);

// File: tb/cfg_bank_test.sv
// Bench for cfg_bank: seeded random operations plus directed corners,
// compared against a bench-side model of the register map.
module cfg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        acc_we = 1'b0;
    logic        acc_sel = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        ld_stb = 1'b0;
    logic [6:0]  ld_idx = '0;
    logic [15:0] ld_data = '0;
    logic        dword_mode, raw_port_active, cfg_valid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [15:0] m [0:127];
    bit          mvalid;
    int          mptr;

    always #4 clk = ~clk;

    cfg_bank uut (
        .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
        .acc_we (acc_we), .acc_sel (acc_sel), .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata), .ld_stb (ld_stb), .ld_idx (ld_idx),
        .ld_data (ld_data), .dword_mode (dword_mode),
        .raw_port_active (raw_port_active), .cfg_valid (cfg_valid)
    );

    function automatic logic [15:0] impl(int idx);
        case (idx)
            2, 3, 5, 6: return 16'hFFFF;
            4:          return 16'h0018;
            default:    return 16'h0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_rd(int idx);
        if (idx == 6) return mvalid ? {16'h0, m[6]} : 32'h0;
        return {16'h0, m[idx] & impl(idx)};
    endfunction

    function automatic bit exp_raw();
        return m[4][4] && (m[5][8:7] == 2'b10);
    endfunction

    task automatic m_hard();
        for (int i = 0; i < 128; i++) m[i] = '0;
        m[2] = 16'h0A40; m[5] = 16'h0001; mvalid = 0; mptr = 0;
    endtask

    task automatic m_sw(int idx, logic [15:0] d);
        if (idx == 6) begin m[6] = d; mvalid = 1; end
        else if (idx == 4) begin if (m[3][15]) m[4] = d & 16'h0018; end
        else m[idx] = d & impl(idx);
    endtask

    task automatic m_ld(int idx, logic [15:0] d);
        if (idx == 6) begin m[6] = d; mvalid = 1; end
        else m[idx] = d & impl(idx);
    endtask

    task automatic m_soft();
        m[2][7] = 1'b0; m[4] = '0;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ptr_wr(int idx);
        acc_we = 1; acc_sel = 0; acc_wdata = {$urandom, 7'(idx)} ;
        acc_wdata[6:0] = 7'(idx);
        @(negedge clk);
        acc_we = 0; acc_sel = 1; mptr = idx;
    endtask

    task automatic sw_wr(logic [31:0] d);
        acc_we = 1; acc_sel = 1; acc_wdata = d;
        @(negedge clk);
        acc_we = 0; m_sw(mptr, d[15:0]);
    endtask

    task automatic ld_wr(int idx, logic [15:0] d);
        ld_stb = 1; ld_idx = 7'(idx); ld_data = d;
        @(negedge clk);
        ld_stb = 0; m_ld(idx, d);
    endtask

    task automatic soft_pulse();
        soft_rst = 1;
        @(negedge clk);
        soft_rst = 0; m_soft();
    endtask

    task automatic rd_chk(string req, int idx);
        ptr_wr(idx);
        acc_sel = 1; #1;
        chk(req, acc_rdata, exp_rd(idx));
    endtask

    task automatic out_chk(string req);
        #1;
        chk({req, " dword_mode"}, {31'h0, dword_mode}, {31'h0, m[2][7]});
        chk({req, " raw_port_active"}, {31'h0, raw_port_active}, {31'h0, exp_raw()});
        chk({req, " cfg_valid"}, {31'h0, cfg_valid}, {31'h0, mvalid});
    endtask

    task automatic hard_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1; m_hard();
    endtask

    task automatic dump_chk(string req);
        for (int k = 0; k < 10; k++) rd_chk(req, (k == 9) ? 127 : k);
        out_chk(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        @(negedge clk);
        hard_reset();
        // R1 R4: pointer and defaults after reset
        acc_sel = 0; #1;
        chk("R1 pointer reset", acc_rdata, 32'h0);
        dump_chk("R4 defaults");

        // R1: pointer readback, upper write bits dropped
        ptr_wr(127); acc_sel = 0; #1;
        chk("R1 pointer readback", acc_rdata, 32'd127);

        // R2 R3: data write with junk upper half, same-cycle read
        ptr_wr(5); sw_wr(32'hDEAD_1234); #1;
        chk("R2 R3 data readback", acc_rdata, 32'h0000_1234);

        // R3: dword mode on, upper half still zero
        ptr_wr(2); sw_wr(32'hFFFF_0080); out_chk("R3 dword on");
        ptr_wr(3); sw_wr(32'hA5A5_0F0F); #1;
        chk("R3 upper zero in dword", acc_rdata, 32'h0000_0F0F);

        // R6: feature write with lock closed is dropped
        ptr_wr(4); sw_wr(32'h0000_FFFF); #1;
        chk("R6 locked write", acc_rdata, 32'h0);
        // R6: open lock, write, absent bits read zero
        ptr_wr(3); sw_wr(32'h0000_8000);
        ptr_wr(4); sw_wr(32'h0000_FFFF); #1;
        chk("R6 unlocked write", acc_rdata, 32'h0000_0018);

        // R10: serial enable plus port select 10
        ptr_wr(5); sw_wr(32'h0000_0100); out_chk("R10 raw port on");
        sw_wr(32'h0000_0180); out_chk("R10 raw port off");

        // R8: scratch invalid, then written by loader
        rd_chk("R8 scratch before write", 6);
        ld_wr(6, 16'hBEEF); rd_chk("R8 scratch after load", 6);
        out_chk("R8 valid");

        // R7: reserved writes by software and loader
        ptr_wr(1); sw_wr(32'h0000_FFFF); ld_wr(7, 16'hFFFF); ld_wr(127, 16'h1111);
        dump_chk("R7 reserved");

        // R5: soft reset keeps pointer, valid, other bits
        ptr_wr(2); sw_wr(32'h0000_00FF);
        ptr_wr(5);
        soft_pulse(); acc_sel = 0; #1;
        chk("R5 pointer kept", acc_rdata, 32'd5);
        dump_chk("R5 soft reset");

        // R9: same-index load wins, different-index both land
        ptr_wr(5);
        acc_we = 1; acc_sel = 1; acc_wdata = 32'h0000_1111;
        ld_stb = 1; ld_idx = 7'd5; ld_data = 16'h2222;
        @(negedge clk);
        acc_we = 0; ld_stb = 0; m_sw(5, 16'h1111); m_ld(5, 16'h2222); #1;
        chk("R9 load wins", acc_rdata, 32'h0000_2222);
        acc_we = 1; acc_wdata = 32'h0000_3333;
        ld_stb = 1; ld_idx = 7'd2; ld_data = 16'h0044;
        @(negedge clk);
        acc_we = 0; ld_stb = 0; m_sw(5, 16'h3333); m_ld(2, 16'h0044);
        dump_chk("R9 both land");
        // R9: loader ignores lock
        ptr_wr(3); sw_wr(32'h0);
        ld_wr(4, 16'h0010); dump_chk("R9 load past lock");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op; int k; int idx;
            op = $urandom % 10;
            k = $urandom % 9; idx = (k == 8) ? 127 : k;
            case (op)
                0, 1: ptr_wr(idx);
                2, 3, 4: sw_wr($urandom);
                5: ld_wr(idx, 16'($urandom));
                6: begin ptr_wr(3); sw_wr({$urandom, ($urandom % 2 == 0), 15'($urandom)}); end
                7: begin ptr_wr(5); sw_wr({$urandom, 7'($urandom), 2'b10, 7'($urandom)}); end
                8: if ($urandom % 4 == 0) soft_pulse(); else ptr_wr(4);
                default: if ($urandom % 20 == 0) hard_reset(); else sw_wr($urandom);
            endcase
            acc_sel = 1; #1;
            chk("R2 R6 R7 random readback", acc_rdata, exp_rd(mptr));
            out_chk("R3 R8 R10 random outputs");
        end
        dump_chk("R2 final dump");

        // R4 R8: hard reset again clears valid and restores defaults
        hard_reset();
        dump_chk("R4 R8 second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule